// File: doc/BRIEF.md
# Eight-Line MIDI Receiver with Tagged Shared Queue

This block receives eight independent MIDI serial lines at 31250 bit/s. One free-running divider makes a single oversampling tick that all eight lines share. Each line has its own small framing state machine, and all of them advance on that common tick. Each finished byte is written, together with the number of the line it came from, into one shared first-in first-out queue of 64 entries. A busy line can therefore fill space that quiet lines leave empty.

A consumer drains the queue through a valid/ready port. Two sets of sticky per-line flags report framing errors and bytes that were lost because the queue was full.

Top module: `midi_rx8_fifo`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pop_valid` is 0 and every bit of `frame_err` and `overflow` is 0.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each data bit lasts `OSR` ticks, and one tick is `TICK_DIV` clock cycles. A good frame on line n appears at the pop port with `pop_chan` = n and `pop_byte` = the data byte.
- R3: Each bit is decided by one sample near its middle. A low pulse that has ended before the middle of the start bit produces no byte and no flag.
- R4: Frames sent back to back with exactly one stop bit and no idle time are all received. The receiver looks for a new start bit as soon as the stop bit has been sampled.
- R5: If the stop-bit sample is low, the byte is discarded and `frame_err[n]` is set. The flag stays set until reset, and later good bytes on that line are still delivered.
- R6: Bytes that several lines finish on the same tick enter the queue in ascending line order, one per cycle.
- R7: The queue holds `DEPTH` (64) entries. A byte that finishes while the queue is full is dropped, the earlier entries are kept unchanged, and `overflow[n]` is set. The flag stays set until reset.
- R8: An entry leaves the queue only in a cycle where `pop_valid` and `pop_ready` are both 1. While `pop_ready` is 0, `pop_valid`, `pop_chan` and `pop_byte` hold their values. Entries come out in the order they were written.
- R9: With `OSR` = 8 the receiver frames bytes whose bits last 8 ticks, with the same result as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_in | input | NCH | Asynchronous serial lines, idle high |
| pop_valid | output | 1 | Queue holds at least one entry |
| pop_ready | input | 1 | Consumer takes the head entry |
| pop_chan | output | CW | Line number of the head entry |
| pop_byte | output | 8 | Data byte of the head entry |
| frame_err | output | NCH | Sticky framing-error flag per line |
| overflow | output | NCH | Sticky lost-byte flag per line |

## Verification
The bench sends a second frame right after a single stop bit. A receiver that waits for extra idle time would lose or corrupt that byte. It lets all eight lines finish on the same tick: a wrong arbiter would drop bytes or deliver them out of line order. It fills the queue to exactly 64 entries and then sends more bytes. A bad full test would either overwrite queued data or flag the wrong line. Short start glitches, a low stop bit and the eight-times sampling variant round out the cases, since a receiver that samples at the wrong point would accept glitches or shift the data bits.

// File: rtl/midi_rx8_fifo.sv
module midi_rx8_fifo #(
  parameter int NCH      = 8,
  parameter int OSR      = 16,
  parameter int TICK_DIV = 100,
  parameter int DEPTH    = 64,
  localparam int CW = $clog2(NCH),
  localparam int PW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1),
  localparam int OW = $clog2(OSR),
  localparam int TW = $clog2(TICK_DIV + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rx_in,
  output logic           pop_valid,
  input  logic           pop_ready,
  output logic [CW-1:0]  pop_chan,
  output logic [7:0]     pop_byte,
  output logic [NCH-1:0] frame_err,
  output logic [NCH-1:0] overflow
);

  logic [TW-1:0]  tdiv;
  logic           tick;
  logic [NCH-1:0] s1, s2, busy, hold_v;
  logic [OW-1:0]  phase  [NCH];
  logic [3:0]     idx    [NCH];
  logic [7:0]     shreg  [NCH];
  logic [7:0]     hold_d [NCH];
  logic [CW-1:0]  sel;
  logic           sel_v, full, wr, pop;
  logic [CW+7:0]  mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [FW-1:0]  fill;

  assign tick      = (tdiv == TW'(TICK_DIV - 1));
  assign full      = (fill == FW'(DEPTH));
  assign wr        = sel_v && !full;
  assign pop_valid = (fill != '0);
  assign pop       = pop_valid && pop_ready;
  assign {pop_chan, pop_byte} = mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    tdiv <= '0;
    else if (tick) tdiv <= '0;
    else           tdiv <= tdiv + 1'b1;

  always_comb begin
    sel_v = 1'b0;
    sel   = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (hold_v[i]) begin
        sel_v = 1'b1;
        sel   = CW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= '1;
      s2        <= '1;
      busy      <= '0;
      hold_v    <= '0;
      frame_err <= '0;
      overflow  <= '0;
      for (int i = 0; i < NCH; i++) begin
        phase[i]  <= '0;
        idx[i]    <= '0;
        shreg[i]  <= '0;
        hold_d[i] <= '0;
      end
    end else begin
      s1 <= rx_in;
      s2 <= s1;
      if (sel_v) begin
        hold_v[sel] <= 1'b0;
        if (full) overflow[sel] <= 1'b1;
      end
      if (tick)
        for (int i = 0; i < NCH; i++) begin
          if (!busy[i]) begin
            if (!s2[i]) begin
              busy[i]  <= 1'b1;
              phase[i] <= OW'(OSR / 2);
              idx[i]   <= '0;
            end
          end else if (phase[i] != OW'(OSR - 1)) begin
            phase[i] <= phase[i] + 1'b1;
          end else begin
            phase[i] <= '0;
            if (idx[i] == 4'd0) begin
              if (s2[i]) busy[i] <= 1'b0;
              else       idx[i]  <= 4'd1;
            end else if (idx[i] != 4'd9) begin
              shreg[i] <= {s2[i], shreg[i][7:1]};
              idx[i]   <= idx[i] + 4'd1;
            end else begin
              busy[i] <= 1'b0;
              if (s2[i]) begin
                hold_v[i] <= 1'b1;
                hold_d[i] <= shreg[i];
              end else begin
                frame_err[i] <= 1'b1;
              end
            end
          end
        end
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {sel, hold_d[sel]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr)  wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (wr && !pop)      fill <= fill + 1'b1;
      else if (pop && !wr) fill <= fill - 1'b1;
    end
  end

endmodule

module midi_rx8_fifo_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(NCH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pop_valid,
  input logic           pop_ready,
  input logic [CW-1:0]  pop_chan,
  input logic [7:0]     pop_byte,
  input logic [NCH-1:0] frame_err,
  input logic [NCH-1:0] overflow,
  input logic [FW-1:0]  fill
);

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pop_valid); // R1

  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_err & $past(frame_err)) == $past(frame_err))); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((overflow & $past(overflow)) == $past(overflow))); // R7

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH)); // R7

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_chan) && $stable(pop_byte))); // R8

endmodule

bind midi_rx8_fifo midi_rx8_fifo_chk #(.NCH(NCH), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .pop_valid(pop_valid), .pop_ready(pop_ready),
  .pop_chan(pop_chan), .pop_byte(pop_byte), .frame_err(frame_err),
  .overflow(overflow), .fill(fill)
);

// File: tb/test_midi_rx8_fifo.sv
module test_midi_rx8_fifo;
  localparam int TD  = 4;
  localparam int B16 = 16 * TD;
  localparam int B8  = 8 * TD;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_a, rx_b;
  logic       ready_a, ready_b;
  logic       pv_a, pv_b;
  logic [2:0] ch_a, ch_b;
  logic [7:0] by_a, by_b, fe_a, fe_b, ov_a, ov_b;

  int          tests = 0, fails = 0;
  bit          done = 0;
  string       tag = "R1";
  logic [10:0] exp_q[$];
  logic [7:0]  exp_fe = '0, exp_ov = '0;
  logic [10:0] held;

  always #2 clk = ~clk;

  midi_rx8_fifo #(.TICK_DIV(TD)) i_midi_rx8_fifo (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_a), .pop_valid(pv_a), .pop_ready(ready_a),
    .pop_chan(ch_a), .pop_byte(by_a), .frame_err(fe_a), .overflow(ov_a));

  midi_rx8_fifo #(.OSR(8), .TICK_DIV(TD)) i_midi_rx8_fifo_x8 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_b), .pop_valid(pv_b), .pop_ready(ready_b),
    .pop_chan(ch_b), .pop_byte(by_b), .frame_err(fe_b), .overflow(ov_b));

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(bit b, int ch, logic v);
    if (b) rx_b[ch] = v;
    else   rx_a[ch] = v;
  endtask

  task automatic send_byte(bit b, int ch, logic [7:0] d, bit stop_ok, int bl);
    drive(b, ch, 1'b0);
    repeat (bl) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      drive(b, ch, d[k]);
      repeat (bl) @(negedge clk);
    end
    drive(b, ch, stop_ok);
    repeat (bl) @(negedge clk);
    drive(b, ch, 1'b1);
  endtask

  task automatic expect_byte(int ch, logic [7:0] d);
    if (exp_q.size() >= 64) exp_ov[ch] = 1'b1;
    else exp_q.push_back({3'(ch), d});
  endtask

  task automatic round(logic [7:0] mask, logic [7:0] base);
    for (int c = 0; c < 8; c++) if (mask[c]) expect_byte(c, base + 8'(c));
    for (int c = 0; c < 8; c++) begin
      automatic int cc = c;
      if (mask[cc]) fork send_byte(0, cc, base + 8'(cc), 1, B16); join_none
    end
    wait fork;
    repeat (B16) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1 && !done) begin
      if (pv_a && exp_q.size() == 0)
        chk(0, {tag, " pop_valid with nothing expected"}, 1, 0);
      else if (pv_a && ready_a) begin
        automatic logic [10:0] e = exp_q.pop_front();
        chk({ch_a, by_a} == e, {tag, " popped entry"}, {ch_a, by_a}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_a = '1; rx_b = '1; ready_a = 1'b0; ready_b = 1'b0;
    repeat (5) @(negedge clk);
    chk(pv_a == 0 && fe_a == 0 && ov_a == 0, "R1 in reset", {pv_a, fe_a, ov_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pv_a == 0 && fe_a == 0 && ov_a == 0, "R1 after reset", {pv_a, fe_a, ov_a}, 0);
    ready_a = 1'b1;

    tag = "R2";
    expect_byte(0, 8'hA5); send_byte(0, 0, 8'hA5, 1, B16);
    expect_byte(7, 8'h3C); send_byte(0, 7, 8'h3C, 1, B16);
    expect_byte(3, 8'h80); send_byte(0, 3, 8'h80, 1, B16);
    expect_byte(3, 8'h01); send_byte(0, 3, 8'h01, 1, B16);
    repeat (2 * B16) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);

    tag = "R3";
    drive(0, 1, 1'b0); repeat (B16 / 4) @(negedge clk); drive(0, 1, 1'b1);
    repeat (12 * B16) @(negedge clk);
    chk(fe_a == 0, "R3 glitch sets no flag", fe_a, 0);
    chk(!pv_a, "R3 glitch gives no byte", pv_a, 0);
    expect_byte(1, 8'h5A); send_byte(0, 1, 8'h5A, 1, B16);
    repeat (2 * B16) @(negedge clk);
    chk(exp_q.size() == 0, "R3 byte after glitch", exp_q.size(), 0);

    tag = "R4";
    expect_byte(4, 8'h12); expect_byte(4, 8'hFE); expect_byte(4, 8'h00);
    send_byte(0, 4, 8'h12, 1, B16);
    send_byte(0, 4, 8'hFE, 1, B16);
    send_byte(0, 4, 8'h00, 1, B16);
    repeat (2 * B16) @(negedge clk);
    chk(exp_q.size() == 0, "R4 back-to-back frames", exp_q.size(), 0);

    tag = "R5";
    send_byte(0, 6, 8'h77, 0, B16);
    exp_fe[6] = 1'b1;
    repeat (3 * B16) @(negedge clk);
    chk(fe_a == exp_fe, "R5 framing flag", fe_a, exp_fe);
    expect_byte(6, 8'h99); send_byte(0, 6, 8'h99, 1, B16);
    repeat (2 * B16) @(negedge clk);
    chk(exp_q.size() == 0, "R5 later byte delivered", exp_q.size(), 0);
    chk(fe_a == exp_fe, "R5 flag sticky", fe_a, exp_fe);

    tag = "R6";
    ready_a = 1'b0;
    round(8'hFF, 8'h40);
    ready_a = 1'b1;
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 simultaneous bytes in line order", exp_q.size(), 0);

    tag = "R7";
    ready_a = 1'b0;
    for (int r = 0; r < 8; r++) round(8'hFF, 8'(r * 16));
    round(8'b0010_0100, 8'hB0);
    chk(ov_a == exp_ov, "R7 overflow flags", ov_a, exp_ov);
    chk(pv_a == 1, "R7 queue holds data", pv_a, 1);
    held = {ch_a, by_a};
    chk(held == exp_q[0], "R8 head is oldest entry", held, exp_q[0]);
    repeat (50) @(negedge clk);
    chk({ch_a, by_a} == held && pv_a, "R8 head held while not ready", {ch_a, by_a}, held);
    tag = "R8";
    ready_a = 1'b1;
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all 64 queued entries kept", exp_q.size(), 0);
    chk(!pv_a, "R8 queue empty after drain", pv_a, 0);
    chk(ov_a == exp_ov, "R7 overflow sticky", ov_a, exp_ov);

    send_byte(1, 3, 8'hC3, 1, B8);
    repeat (2 * B8) @(negedge clk);
    chk(pv_b && ch_b == 3 && by_b == 8'hC3, "R9 eight-times sampling", {pv_b, ch_b, by_b}, {1'b1, 3'd3, 8'hC3});
    ready_b = 1'b1; @(negedge clk); ready_b = 1'b0;
    @(negedge clk);
    chk(!pv_b, "R9 single entry popped", pv_b, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule